// File: doc/BRIEF.md
# Capacity LED Gauge Driver

This block turns a remaining-capacity percentage into drive enables for a five-segment LED gauge. It is configured once after reset with one of three presentation styles. In incremental style a single segment marks the band that holds the charge level. In binary style two segments encode four bands. In bar style a cumulative column of up to five segments is lit. The gauge stays dark until a push-button style request, active low, opens a timed display window. The window is longer in incremental style than in the other two.

While the window is open, the common LED supply enable is asserted. The odd-numbered segments (1, 3, 5) and the even-numbered segments (2, 4) are lit in two alternating banks, each for 30% of a multiplex period, so the two banks never conduct at the same time. Two low-voltage flags override the level pattern. The warning flag makes segment 1 blink on its own in incremental and bar styles. The final flag blanks every segment in all styles.

All time constants count clock cycles through parameters. The multiplex phase length, the blink half-period in multiplex periods and the two window lengths in multiplex periods can all be set. With the defaults and a 32.768 kHz clock they give a period of about 100 Hz, a blink of about 4 Hz and windows of about 4 s and 10 s.

Top module: `cap_led_gauge`

## Requirements
- R1: While rst_n is low, seg_on is 5'b00000 and led_com_en is 0.
- R2: The style is taken from mode_sel on the first rising clock edge after reset is released, with 2'b00 for incremental, 2'b01 for binary, and 2'b10 or 2'b11 for bar. Later changes of mode_sel have no effect until the next reset.
- R3: In incremental style, exactly one of seg_on[3:0] is selected: bit 3 for 90..100, bit 2 for 50..89, bit 1 for 20..49 and bit 0 below 20. seg_on[4] is never lit.
- R4: In binary style, bits 0 and 1 are both selected for 70..100, bit 0 alone for 40..69, bit 1 alone for 10..39, and neither below 10. seg_on[4:2] are never lit.
- R5: In bar style, seg_on[0] is always selected. Bits 1, 2, 3 and 4 are added at 20, 40, 60 and 80 respectively.
- R6: A pct value above 100 gives the same pattern as 100.
- R7: A clock edge that samples disp_req_n low, from the second edge after reset onward, reloads the window to WIN_LONG_PER×10×PHASE_CYC cycles in incremental style and to WIN_SHORT_PER×10×PHASE_CYC cycles otherwise. The window stays open for that many cycles after the last such edge, so a new request restarts it.
- R8: led_com_en is 1 exactly while the window is open. seg_on is 0 while it is closed.
- R9: The period is 10 phases of PHASE_CYC cycles each, counted from reset. Selected bits 0, 2 and 4 are lit only in phases 0..2, and bits 1 and 3 are lit only in phases 5..7.
- R10: With low_warn set in incremental or bar style, only seg_on[0] may be lit. It is lit during the first BLINK_HALF_PER periods after reset and then on alternating groups of BLINK_HALF_PER periods.
- R11: In binary style, low_warn has no effect on seg_on.
- R12: While low_final is 1, seg_on is 0 in every style.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Presentation style, sampled once after reset |
| disp_req_n | input | 1 | Active-low display request |
| pct | input | PCT_W | Remaining capacity in percent, unsigned |
| low_warn | input | 1 | First low-voltage flag |
| low_final | input | 1 | Final low-voltage flag |
| seg_on | output | 5 | Segment enables, bit 0 is segment 1, 1 means lit |
| led_com_en | output | 1 | Common LED supply enable |

## Verification
The assertions assume that pct, the two flags and disp_req_n only change away from the clock edge, and that mode_sel is stable at the edge that loads the style. The bench changes every input at the falling edge only. It reloads the style through a full reset and otherwise only wiggles mode_sel to show that the change is ignored. The flags are treated as independent inputs, so the final flag may appear without the warning flag, and the bench drives that combination on purpose.

// File: rtl/cap_disp_pkg.sv
package cap_disp_pkg;
   typedef enum logic [1:0] {
      DM_INCR    = 2'd0,
      DM_BINARY  = 2'd1,
      DM_BAR     = 2'd2,
      DM_BAR_ALT = 2'd3
   } disp_mode_e;

   localparam int unsigned NUM_SEG     = 5;
   localparam int unsigned MUX_PHASES  = 10;
   localparam int unsigned BANK_DUTY   = 30;
endpackage

// File: rtl/cap_level_map.sv
module cap_level_map
   import cap_disp_pkg::*;
#(
   parameter int unsigned PCT_W      = 7,
   parameter int unsigned FULL_SCALE = 100
) (
   input  disp_mode_e          mode,
   input  logic [PCT_W-1:0]    pct,
   output logic [NUM_SEG-1:0]  pattern
);
   localparam int unsigned T10 = FULL_SCALE * 1 / 10;
   localparam int unsigned T20 = FULL_SCALE * 2 / 10;
   localparam int unsigned T40 = FULL_SCALE * 4 / 10;
   localparam int unsigned T50 = FULL_SCALE * 5 / 10;
   localparam int unsigned T70 = FULL_SCALE * 7 / 10;
   localparam int unsigned T90 = FULL_SCALE * 9 / 10;

   logic [PCT_W-1:0]   lvl;
   logic [NUM_SEG-1:0] inc_pat;
   logic [NUM_SEG-1:0] bar_pat;
   logic [NUM_SEG-1:0] bin_pat;

   // clamp values above full scale
   assign lvl = (pct > PCT_W'(FULL_SCALE)) ? PCT_W'(FULL_SCALE) : pct;

   // bar style: cumulative steps every fifth of full scale
   for (genvar i = 0; i < NUM_SEG; i++) begin : g_bar
      if (i == 0) begin : g_base
         assign bar_pat[i] = 1'b1;
      end else begin : g_step
         assign bar_pat[i] = (lvl >= PCT_W'(FULL_SCALE * 2 * i / 10));
      end
   end

   // incremental style: one band per segment, top segment unused
   for (genvar i = 0; i < NUM_SEG; i++) begin : g_inc
      localparam int unsigned LO = (i == 1) ? T20 : (i == 2) ? T50 : T90;
      localparam int unsigned HI = (i == 1) ? T50 : (i == 2) ? T90 : FULL_SCALE + 1;
      if (i == 0) begin : g_low
         assign inc_pat[i] = (lvl < PCT_W'(T20));
      end else if (i < NUM_SEG - 1) begin : g_band
         assign inc_pat[i] = (lvl >= PCT_W'(LO)) && (lvl < PCT_W'(HI));
      end else begin : g_unused
         assign inc_pat[i] = 1'b0;
      end
   end

   // binary style: two-bit band code on segments 1 and 2
   assign bin_pat[0] = (lvl >= PCT_W'(T40));
   assign bin_pat[1] = (lvl >= PCT_W'(T70)) ||
                       ((lvl >= PCT_W'(T10)) && (lvl < PCT_W'(T40)));
   assign bin_pat[NUM_SEG-1:2] = '0;

   always_comb begin
      unique case (mode)
         DM_INCR:   pattern = inc_pat;
         DM_BINARY: pattern = bin_pat;
         default:   pattern = bar_pat;
      endcase
   end
endmodule

// File: rtl/cap_mux_timebase.sv
module cap_mux_timebase
   import cap_disp_pkg::*;
#(
   parameter int unsigned PHASE_CYC      = 33,
   parameter int unsigned BLINK_HALF_PER = 12
) (
   input  logic clk,
   input  logic rst_n,
   output logic bank_a_act,
   output logic bank_b_act,
   output logic blink_on
);
   localparam int unsigned SUB_W    = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
   localparam int unsigned PH_W     = $clog2(MUX_PHASES);
   localparam int unsigned BL_W     = (BLINK_HALF_PER > 1) ? $clog2(BLINK_HALF_PER) : 1;
   localparam int unsigned ON_PH    = MUX_PHASES * BANK_DUTY / 100;
   localparam int unsigned B_START  = MUX_PHASES / 2;

   logic [SUB_W-1:0] sub_q;
   logic [PH_W-1:0]  phase_q;
   logic [BL_W-1:0]  per_q;
   logic             blink_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub_q   <= '0;
         phase_q <= '0;
         per_q   <= '0;
         blink_q <= 1'b1;
      end else if (sub_q == SUB_W'(PHASE_CYC - 1)) begin
         sub_q <= '0;
         if (phase_q == PH_W'(MUX_PHASES - 1)) begin
            phase_q <= '0;
            if (per_q == BL_W'(BLINK_HALF_PER - 1)) begin
               per_q   <= '0;
               blink_q <= ~blink_q;
            end else begin
               per_q <= per_q + 1'b1;
            end
         end else begin
            phase_q <= phase_q + 1'b1;
         end
      end else begin
         sub_q <= sub_q + 1'b1;
      end
   end

   assign bank_a_act = (phase_q < PH_W'(ON_PH));
   assign bank_b_act = (phase_q >= PH_W'(B_START)) &&
                       (phase_q <  PH_W'(B_START + ON_PH));
   assign blink_on   = blink_q;
endmodule

// File: rtl/cap_window_timer.sv
module cap_window_timer #(
   parameter int unsigned SHORT_CYC = 132000,
   parameter int unsigned LONG_CYC  = 330000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic long_sel,
   output logic open
);
   localparam int unsigned MAX_CYC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
   localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

   logic [CNT_W-1:0] rem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
      end else if (start) begin
         rem_q <= long_sel ? CNT_W'(LONG_CYC) : CNT_W'(SHORT_CYC);
      end else if (rem_q != '0) begin
         rem_q <= rem_q - 1'b1;
      end
   end

   assign open = (rem_q != '0);
endmodule

// File: rtl/cap_led_gauge.sv
module cap_led_gauge
   import cap_disp_pkg::*;
#(
   parameter int unsigned PHASE_CYC      = 33,
   parameter int unsigned BLINK_HALF_PER = 12,
   parameter int unsigned WIN_SHORT_PER  = 400,
   parameter int unsigned WIN_LONG_PER   = 1000,
   parameter int unsigned PCT_W          = 7,
   parameter int unsigned FULL_SCALE     = 100
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode_sel,
   input  logic             disp_req_n,
   input  logic [PCT_W-1:0] pct,
   input  logic             low_warn,
   input  logic             low_final,
   output logic [4:0]       seg_on,
   output logic             led_com_en
);
   localparam int unsigned PERIOD_CYC = PHASE_CYC * MUX_PHASES;
   localparam int unsigned SHORT_CYC  = WIN_SHORT_PER * PERIOD_CYC;
   localparam int unsigned LONG_CYC   = WIN_LONG_PER * PERIOD_CYC;

   if (PHASE_CYC < 1) begin : g_bad_phase
      $error("PHASE_CYC must be at least 1");
   end
   if (BLINK_HALF_PER < 1) begin : g_bad_blink
      $error("BLINK_HALF_PER must be at least 1");
   end
   if (WIN_SHORT_PER < 1 || WIN_LONG_PER < 1) begin : g_bad_win
      $error("window lengths must be at least one period");
   end
   if (FULL_SCALE + 1 >= (1 << PCT_W)) begin : g_bad_scale
      $error("FULL_SCALE does not fit PCT_W");
   end

   disp_mode_e         mode_q;
   logic               cfg_valid;
   logic [NUM_SEG-1:0] level_pat;
   logic [NUM_SEG-1:0] shown_pat;
   logic [NUM_SEG-1:0] bank_mask;
   logic               bank_a, bank_b, blink_on, win_open;
   logic               blink_mode;

   // style is captured once, on the first edge after reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_valid <= 1'b0;
         mode_q    <= DM_BAR;
      end else if (!cfg_valid) begin
         cfg_valid <= 1'b1;
         mode_q    <= disp_mode_e'(mode_sel);
      end
   end

   cap_level_map #(
      .PCT_W      (PCT_W),
      .FULL_SCALE (FULL_SCALE)
   ) i_level_map (
      .mode    (mode_q),
      .pct     (pct),
      .pattern (level_pat)
   );

   cap_mux_timebase #(
      .PHASE_CYC      (PHASE_CYC),
      .BLINK_HALF_PER (BLINK_HALF_PER)
   ) i_timebase (
      .clk        (clk),
      .rst_n      (rst_n),
      .bank_a_act (bank_a),
      .bank_b_act (bank_b),
      .blink_on   (blink_on)
   );

   cap_window_timer #(
      .SHORT_CYC (SHORT_CYC),
      .LONG_CYC  (LONG_CYC)
   ) i_window (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (cfg_valid && !disp_req_n),
      .long_sel (mode_q == DM_INCR),
      .open     (win_open)
   );

   for (genvar i = 0; i < NUM_SEG; i++) begin : g_bank
      if (i % 2 == 0) begin : g_odd_seg
         assign bank_mask[i] = bank_a;
      end else begin : g_even_seg
         assign bank_mask[i] = bank_b;
      end
   end

   assign blink_mode = (mode_q != DM_BINARY);

   // final flag blanks; warning flag replaces the pattern with segment 1 blink
   always_comb begin
      if (low_final) begin
         shown_pat = '0;
      end else if (low_warn && blink_mode) begin
         shown_pat    = '0;
         shown_pat[0] = blink_on;
      end else begin
         shown_pat = level_pat;
      end
   end

   assign seg_on     = win_open ? (shown_pat & bank_mask) : '0;
   assign led_com_en = win_open;
endmodule

// File: rtl/cap_led_gauge_chk.sv
module cap_led_gauge_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       disp_req_n,
   input logic       low_warn,
   input logic       low_final,
   input logic       cfg_valid,
   input logic [1:0] mode_q,
   input logic [4:0] seg_on,
   input logic       led_com_en
);
   AST_REQ_OPENS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_valid && !disp_req_n) |=> led_com_en); // R7

   AST_DARK_WHEN_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
      !led_com_en |-> (seg_on == 5'b0)); // R8

   AST_BANKS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !((|(seg_on & 5'b10101)) && (|(seg_on & 5'b01010)))); // R9

   AST_FINAL_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
      low_final |-> (seg_on == 5'b0)); // R12

   AST_WARN_SEG1_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (low_warn && mode_q != 2'd1) |-> (seg_on[4:1] == 4'b0)); // R10

   AST_INCR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_valid && mode_q == 2'd0) |-> ($onehot0(seg_on) && !seg_on[4])); // R3

   AST_BINARY_LOW_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_valid && mode_q == 2'd1) |-> (seg_on[4:2] == 3'b0)); // R4
endmodule

bind cap_led_gauge cap_led_gauge_chk i_cap_led_gauge_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .disp_req_n (disp_req_n),
   .low_warn   (low_warn),
   .low_final  (low_final),
   .cfg_valid  (cfg_valid),
   .mode_q     (mode_q),
   .seg_on     (seg_on),
   .led_com_en (led_com_en)
);

// File: tb/test_cap_led_gauge.sv
`timescale 1ns/1ps
module test_cap_led_gauge;
   localparam int PHASE_CYC = 2;
   localparam int BLINK_HALF = 3;
   localparam int WIN_SHORT = 6;
   localparam int WIN_LONG = 15;
   localparam int PERIOD = PHASE_CYC * 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode_sel = 2'd0;
   logic       disp_req_n = 1'b1;
   logic [6:0] pct = 7'd50;
   logic       low_warn = 1'b0;
   logic       low_final = 1'b0;
   logic [4:0] seg_on;
   logic       led_com_en;

   int n_checks = 0;
   int n_fails = 0;
   bit done = 1'b0;

   // reference state
   int t = 0;
   int rem = 0;
   bit started = 1'b0;
   logic [1:0] m_mode = 2'd2;

   always #2 clk = ~clk;

   cap_led_gauge #(
      .PHASE_CYC      (PHASE_CYC),
      .BLINK_HALF_PER (BLINK_HALF),
      .WIN_SHORT_PER  (WIN_SHORT),
      .WIN_LONG_PER   (WIN_LONG),
      .PCT_W          (7),
      .FULL_SCALE     (100)
   ) i_cap_led_gauge (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_sel   (mode_sel),
      .disp_req_n (disp_req_n),
      .pct        (pct),
      .low_warn   (low_warn),
      .low_final  (low_final),
      .seg_on     (seg_on),
      .led_com_en (led_com_en)
   );

   function automatic int win_len(logic [1:0] m);
      return (m == 2'd0) ? WIN_LONG * PERIOD : WIN_SHORT * PERIOD;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         t = 0; rem = 0; started = 1'b0;
      end else begin
         if (started && !disp_req_n) rem = win_len(m_mode);
         else if (rem > 0) rem = rem - 1;
         if (!started) begin
            m_mode = mode_sel;
            started = 1'b1;
         end
         t = t + 1;
      end
   end

   function automatic logic [4:0] level_of(logic [1:0] m, int p);
      int c;
      c = (p > 100) ? 100 : p;
      if (m == 2'd0) begin
         if (c >= 90) return 5'b01000;
         if (c >= 50) return 5'b00100;
         if (c >= 20) return 5'b00010;
         return 5'b00001;
      end else if (m == 2'd1) begin
         if (c >= 70) return 5'b00011;
         if (c >= 40) return 5'b00001;
         if (c >= 10) return 5'b00010;
         return 5'b00000;
      end
      if (c >= 80) return 5'b11111;
      if (c >= 60) return 5'b01111;
      if (c >= 40) return 5'b00111;
      if (c >= 20) return 5'b00011;
      return 5'b00001;
   endfunction

   function automatic logic [4:0] exp_seg();
      logic [4:0] pat;
      int ph;
      bit blink;
      if (!rst_n || rem == 0) return 5'b0;
      if (low_final) return 5'b0;
      blink = ((t / (PERIOD * BLINK_HALF)) % 2) == 0;
      if (low_warn && m_mode != 2'd1) pat = {4'b0, blink};
      else pat = level_of(m_mode, int'(pct));
      ph = (t / PHASE_CYC) % 10;
      if (!(ph < 3)) pat = pat & 5'b01010;
      if (!(ph >= 5 && ph < 8)) pat = pat & 5'b10101;
      return pat;
   endfunction

   function automatic string tag_of();
      string s;
      if (!rst_n) return "R1";
      if (rem == 0) return "R8";
      if (low_final) s = "R12";
      else if (low_warn && m_mode != 2'd1) s = "R10";
      else if (low_warn) s = "R11";
      else if (pct > 7'd100) s = "R6";
      else if (m_mode == 2'd0) s = "R3 (style per R2)";
      else if (m_mode == 2'd1) s = "R4 (style per R2)";
      else s = "R5 (style per R2)";
      return {s, " R9"};
   endfunction

   task automatic check_now();
      logic [4:0] es;
      logic ec;
      es = exp_seg();
      ec = rst_n && (rem != 0);
      n_checks++;
      if (seg_on !== es) begin
         n_fails++;
         $display("FAIL %s seg_on actual %b expected %b at t=%0d", tag_of(), seg_on, es, t);
      end
      n_checks++;
      if (led_com_en !== ec) begin
         n_fails++;
         $display("FAIL %s led_com_en actual %b expected %b at t=%0d",
                  rst_n ? "R7" : "R1", led_com_en, ec, t);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      check_now();
   endtask

   task automatic run_mode(logic [1:0] m);
      rst_n = 1'b0; mode_sel = m; disp_req_n = 1'b1;
      low_warn = 1'b0; low_final = 1'b0; pct = 7'd50;
      repeat (3) tick();             // R1 reset state
      rst_n = 1'b1;
      tick();
      mode_sel = ~m;                 // R2: later change ignored
      // directed sweep over every pct value, boundaries included (R3 R4 R5 R6)
      for (int p = 0; p < 128; p++) begin
         pct = 7'(p); disp_req_n = 1'b0;
         tick();
         disp_req_n = 1'b1;
         repeat (PERIOD - 1) tick();
      end
      // let the window run out (R7 R8)
      repeat (win_len(m) + 5) tick();
      // warning blink over several blink groups (R10 R11)
      pct = 7'd95; disp_req_n = 1'b0; low_warn = 1'b1;
      repeat (PERIOD * BLINK_HALF * 3) tick();
      // final flag alone and with warning (R12)
      low_warn = 1'b0; low_final = 1'b1;
      repeat (PERIOD * 2) tick();
      low_warn = 1'b1;
      repeat (PERIOD) tick();
      low_warn = 1'b0; low_final = 1'b0; disp_req_n = 1'b1;
      // random mix, restart of an open window included (R7)
      for (int k = 0; k < 3000; k++) begin
         tick();
         disp_req_n = ($urandom % 150 == 0) ? 1'b0 : 1'b1;
         if ($urandom % 25 == 0) pct = 7'($urandom % 128);
         if ($urandom % 300 == 0) low_warn = ~low_warn;
         if ($urandom % 500 == 0) low_final = ~low_final;
         if ($urandom % 40 == 0) mode_sel = 2'($urandom);
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   endtask

   initial begin
      void'($urandom(32'h1D5E_ED07));
      run_mode(2'd0);
      run_mode(2'd1);
      run_mode(2'd2);
      run_mode(2'd3);
      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         finish_run();
      end
   end
endmodule